// File: doc/BRIEF.md
# Offset Register Serial/Parallel Loader

This block fills the four threshold offsets of a bidirectional dual-FIFO: an almost-full and an almost-empty offset for each direction. The offsets are named Y1, X1, Y2 and X2. They can be loaded in one of two ways, and the way is chosen while master reset is asserted. In serial mode, the four offsets form one 52-bit chain. The chain is shifted in one bit per port A clock, with the most significant bit first. In parallel mode, each offset is written as one word from the port A data bus. If the interspersed-parity option is selected, the parallel word skips bit 8.

Both ports report readiness through a flag. The port A flag rises on the port A clock edge after the last offset bit or word is taken. The port B flag follows it through a two-flop synchronizer in the port B clock domain. The loaded offsets are exported for the threshold comparators, which live outside this block. Once loading is complete, further input is ignored until the next master reset.

Top module: `offset_serial_loader`

## Requirements
- R1: The load mode is captured from the mode pins on each port A clock edge while `rst_a` is high. Serial mode is chosen only when `mode_hi`=0, `shift_bit`=0, `shift_en_n`=1 and `parity_mix`=0. Every other combination chooses parallel mode, and in parallel mode serial bits are ignored.
- R2: In serial mode, one `shift_bit` value is captured on each rising `clk_a` edge where `shift_en_n` is 0. Edges where `shift_en_n` is 1 capture nothing.
- R3: The serial chain is filled in the order Y1, X1, Y2, X2. Each offset is 13 bits. The first captured bit is bit 12 of Y1, and the 52nd bit is bit 0 of X2.
- R4: `rdy_a_o` stays 0 until the final bit or word is taken. It rises on the next `clk_a` edge after that and then stays 1 until reset.
- R5: `rdy_b_o` stays 0 during loading. It rises within a few `clk_b` edges after `rdy_a_o`, through a two-flop synchronizer, and then stays 1 until `rst_b`.
- R6: When `parity_mix` is 1 during reset, serial mode is refused. Serial bits then change neither the offsets nor the flags.
- R7: In parallel mode, four cycles with `ld_we`=1 load Y1, X1, Y2 and X2 in that order. `rdy_a_o` rises on the `clk_a` edge after the fourth write.
- R8: With interspersed parity, the offset is built as {`ld_data`[13:9], `ld_data`[7:0]} and `ld_data`[8] is ignored. Without parity, the offset is `ld_data`[12:0].
- R9: After loading is complete, further serial bits and parallel writes leave the offsets unchanged until the next master reset.
- R10: During reset, `rdy_a_o` and `rdy_b_o` are 0 and all four offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, which drives all loading |
| rst_a | input | 1 | Synchronous active-high master reset, port A domain |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, port B domain |
| mode_hi | input | 1 | Mode pin, sampled during reset |
| shift_bit | input | 1 | Mode pin during reset, serial data afterwards |
| shift_en_n | input | 1 | Mode pin during reset, active-low shift enable afterwards |
| parity_mix | input | 1 | Interspersed-parity select, sampled during reset |
| ld_we | input | 1 | Parallel word write strobe |
| ld_data | input | 36 | Parallel word |
| y1_o | output | 13 | Loaded offset Y1 |
| x1_o | output | 13 | Loaded offset X1 |
| y2_o | output | 13 | Loaded offset Y2 |
| x2_o | output | 13 | Loaded offset X2 |
| rdy_a_o | output | 1 | Port A ready flag |
| rdy_b_o | output | 1 | Port B ready flag |

## Verification
The assertions assume the following about the inputs:
- Master reset is held for at least two port A cycles.
- The mode pins stay steady for the whole of reset, so the captured mode is never sampled mid-change.
- `rst_b` overlaps `rst_a`.

The bench holds every mode pin constant across each reset window and changes inputs only on falling clock edges. It keeps the two resets asserted together for four port A cycles. Idle cycles with noise on `shift_bit` are mixed into the serial streams to exercise the shift enable without breaking these assumptions.

// File: rtl/offset_loader_pkg.sv
package offset_loader_pkg;

    // Four offsets: two thresholds for each transfer direction
    localparam int N_OFFS     = 4;
    localparam int DEF_OFS_W  = 13;
    localparam int DEF_DATA_W = 36;
    localparam int DEF_PAR_BIT = 8;

    // Slot positions; the highest slot is shifted in first
    localparam int SLOT_Y1 = 3;
    localparam int SLOT_X1 = 2;
    localparam int SLOT_Y2 = 1;
    localparam int SLOT_X2 = 0;

    typedef enum logic [0:0] {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    // Decode the reset-time strap pins into a load mode
    function automatic load_mode_e decode_mode(
        input logic hi,
        input logic bit_v,
        input logic en_n,
        input logic par
    );
        if (!hi && !bit_v && en_n && !par) begin
            return LOAD_SERIAL;
        end
        return LOAD_PARALLEL;
    endfunction

endpackage

// File: rtl/olc_mode_latch.sv
module olc_mode_latch
    import offset_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_hi,
    input  logic       shift_bit,
    input  logic       shift_en_n,
    input  logic       parity_mix,
    output load_mode_e mode_o,
    output logic       par_o
);

    load_mode_e mode_q;
    logic       par_q;

    // Straps are captured only while master reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_mode(mode_hi, shift_bit, shift_en_n, parity_mix);
            par_q  <= parity_mix;
        end
    end

    assign mode_o = mode_q;
    assign par_o  = par_q;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(mode_q) && $stable(par_q)));

endmodule

// File: rtl/olc_serial_shift.sv
module olc_serial_shift
    import offset_loader_pkg::*;
#(
    parameter int OFS_W = DEF_OFS_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          shift_bit,
    input  logic                          shift_en_n,
    output logic [N_OFFS-1:0][OFS_W-1:0]  bank_o,
    output logic                          done_o
);

    localparam int TOT   = N_OFFS * OFS_W;
    localparam int CNT_W = $clog2(TOT + 1);

    logic [TOT-1:0]   chain;
    logic [CNT_W-1:0] cnt;
    logic             done;

    assign done = (cnt == CNT_W'(TOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            cnt   <= '0;
        end else if (en && !shift_en_n && !done) begin
            chain <= {chain[TOT-2:0], shift_bit};
            cnt   <= cnt + CNT_W'(1);
        end
    end

    // The first bit ends up in the top slot (Y1); the last bit is the LSB of X2
    for (genvar r = 0; r < N_OFFS; r++) begin : g_slot
        assign bank_o[r] = chain[r*OFS_W +: OFS_W];
    end

    assign done_o = done;

    // R2
    shift_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ($past(!shift_en_n) && $past(en)));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(TOT));

    // R9
    chain_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(chain));

endmodule

// File: rtl/olc_par_load.sv
module olc_par_load
    import offset_loader_pkg::*;
#(
    parameter int OFS_W   = DEF_OFS_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int PAR_BIT = DEF_PAR_BIT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          par_il,
    input  logic                          ld_we,
    input  logic [OFS_W:0]                ld_bits,
    output logic [N_OFFS-1:0][OFS_W-1:0]  bank_o,
    output logic                          done_o
);

    localparam int IDX_W  = $clog2(N_OFFS + 1);
    localparam int SLOT_W = $clog2(N_OFFS);
    localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(N_OFFS - 1);

    logic [N_OFFS-1:0][OFS_W-1:0] bank_q;
    logic [IDX_W-1:0]             widx;
    logic [OFS_W-1:0]             word_val;
    logic [SLOT_W-1:0]            slot;
    logic                         done;

    // Bits at or above the parity position move down by one when parity is interleaved
    for (genvar k = 0; k < OFS_W; k++) begin : g_bit
        if (k < PAR_BIT) begin : g_low
            assign word_val[k] = ld_bits[k];
        end else begin : g_high
            assign word_val[k] = par_il ? ld_bits[k+1] : ld_bits[k];
        end
    end

    assign done = (widx == IDX_W'(N_OFFS));
    assign slot = TOP_SLOT - widx[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            widx   <= '0;
        end else if (en && ld_we && !done) begin
            bank_q[slot] <= word_val;
            widx         <= widx + IDX_W'(1);
        end
    end

    assign bank_o = bank_q;
    assign done_o = done;

    // R7
    widx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        widx <= IDX_W'(N_OFFS));

    // R9
    bank_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(bank_q));

endmodule

// File: rtl/olc_ready_xing.sv
module olc_ready_xing (
    input  logic clk_b,
    input  logic rst_b,
    input  logic rdy_a_i,
    output logic rdy_b_o
);

    logic meta1;
    logic meta2;
    logic rdy_b_q;

    always_ff @(posedge clk_b) begin
        if (rst_b) begin
            meta1   <= 1'b0;
            meta2   <= 1'b0;
            rdy_b_q <= 1'b0;
        end else begin
            meta1   <= rdy_a_i;
            meta2   <= meta1;
            rdy_b_q <= rdy_b_q | meta2;
        end
    end

    assign rdy_b_o = rdy_b_q;

    // R5
    rdy_b_sticky_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        rdy_b_q |=> rdy_b_q);

endmodule

// File: rtl/offset_serial_loader.sv
module offset_serial_loader
    import offset_loader_pkg::*;
#(
    parameter int OFS_W   = DEF_OFS_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int PAR_BIT = DEF_PAR_BIT
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              mode_hi,
    input  logic              shift_bit,
    input  logic              shift_en_n,
    input  logic              parity_mix,
    input  logic              ld_we,
    input  logic [DATA_W-1:0] ld_data,
    output logic [OFS_W-1:0]  y1_o,
    output logic [OFS_W-1:0]  x1_o,
    output logic [OFS_W-1:0]  y2_o,
    output logic [OFS_W-1:0]  x2_o,
    output logic              rdy_a_o,
    output logic              rdy_b_o
);

    load_mode_e                   mode;
    logic                         par_il;
    logic                         ser_en;
    logic                         par_en;
    logic [N_OFFS-1:0][OFS_W-1:0] ser_bank;
    logic [N_OFFS-1:0][OFS_W-1:0] par_bank;
    logic [N_OFFS-1:0][OFS_W-1:0] bank_sel;
    logic                         ser_done;
    logic                         par_done;
    logic                         done_a;
    logic                         rdy_a_q;
    logic                         unused_hi;

    assign unused_hi = ^ld_data[DATA_W-1:OFS_W+1];

    olc_mode_latch u_mode (
        .clk        (clk_a),
        .rst        (rst_a),
        .mode_hi    (mode_hi),
        .shift_bit  (shift_bit),
        .shift_en_n (shift_en_n),
        .parity_mix (parity_mix),
        .mode_o     (mode),
        .par_o      (par_il)
    );

    assign ser_en = (mode == LOAD_SERIAL);
    assign par_en = (mode == LOAD_PARALLEL);

    olc_serial_shift #(.OFS_W(OFS_W)) u_ser (
        .clk        (clk_a),
        .rst        (rst_a),
        .en         (ser_en),
        .shift_bit  (shift_bit),
        .shift_en_n (shift_en_n),
        .bank_o     (ser_bank),
        .done_o     (ser_done)
    );

    olc_par_load #(
        .OFS_W   (OFS_W),
        .DATA_W  (DATA_W),
        .PAR_BIT (PAR_BIT)
    ) u_par (
        .clk     (clk_a),
        .rst     (rst_a),
        .en      (par_en),
        .par_il  (par_il),
        .ld_we   (ld_we),
        .ld_bits (ld_data[OFS_W:0]),
        .bank_o  (par_bank),
        .done_o  (par_done)
    );

    assign bank_sel = ser_en ? ser_bank : par_bank;
    assign done_a   = ser_en ? ser_done : par_done;

    // Port A flag rises one edge after the last bit or word
    always_ff @(posedge clk_a) begin
        if (rst_a) begin
            rdy_a_q <= 1'b0;
        end else begin
            rdy_a_q <= done_a;
        end
    end

    olc_ready_xing u_xing (
        .clk_b   (clk_b),
        .rst_b   (rst_b),
        .rdy_a_i (rdy_a_q),
        .rdy_b_o (rdy_b_o)
    );

    assign y1_o    = bank_sel[SLOT_Y1];
    assign x1_o    = bank_sel[SLOT_X1];
    assign y2_o    = bank_sel[SLOT_Y2];
    assign x2_o    = bank_sel[SLOT_X2];
    assign rdy_a_o = rdy_a_q;

    // R4
    rdy_a_sticky_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        rdy_a_q |=> rdy_a_q);

    // R4
    rdy_a_needs_done_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        rdy_a_q |-> done_a);

    // R6
    serial_refused_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        par_il |-> !ser_done);

endmodule

// File: tb/offset_serial_loader_tb_top.sv
module offset_serial_loader_tb_top;

    localparam int OW = 13;
    localparam int DW = 36;
    localparam int NV = 4;

    // Vector fields: {Y1, X1, Y2, X2, idle gap}
    localparam logic [4*OW+3:0] VEC [0:NV-1] = '{
        {13'd1,    13'd8188, 13'd4096, 13'd2,    4'd0},
        {13'h1555, 13'h0AAA, 13'h0AAA, 13'h1555, 4'd3},
        {13'd1,    13'd1,    13'd1,    13'd1,    4'd1},
        {13'd8188, 13'd8188, 13'd8188, 13'd8188, 4'd7}
    };

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    always #4 clk_a = ~clk_a;
    always #5 clk_b = ~clk_b;

    logic          rst_a = 1'b1;
    logic          rst_b = 1'b1;
    logic          mode_hi = 1'b0;
    logic          shift_bit = 1'b0;
    logic          shift_en_n = 1'b1;
    logic          parity_mix = 1'b0;
    logic          ld_we = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic [OW-1:0] y1_o, x1_o, y2_o, x2_o;
    logic          rdy_a_o, rdy_b_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    offset_serial_loader dut_i (
        .clk_a      (clk_a),
        .rst_a      (rst_a),
        .clk_b      (clk_b),
        .rst_b      (rst_b),
        .mode_hi    (mode_hi),
        .shift_bit  (shift_bit),
        .shift_en_n (shift_en_n),
        .parity_mix (parity_mix),
        .ld_we      (ld_we),
        .ld_data    (ld_data),
        .y1_o       (y1_o),
        .x1_o       (x1_o),
        .y2_o       (y2_o),
        .x2_o       (x2_o),
        .rdy_a_o    (rdy_a_o),
        .rdy_b_o    (rdy_b_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic hi, input logic b, input logic en_n, input logic par);
        @(negedge clk_a);
        rst_a = 1'b1; rst_b = 1'b1; ld_we = 1'b0;
        mode_hi = hi; shift_bit = b; shift_en_n = en_n; parity_mix = par;
        repeat (4) @(negedge clk_a);
        rst_a = 1'b0; rst_b = 1'b0;
        shift_en_n = 1'b1; shift_bit = 1'b0;
    endtask

    task automatic shift_one(input logic b);
        shift_bit = b; shift_en_n = 1'b0;
        @(negedge clk_a);
        shift_en_n = 1'b1;
    endtask

    task automatic idle_one(input logic junk);
        shift_bit = junk; shift_en_n = 1'b1;
        @(negedge clk_a);
    endtask

    task automatic par_write(input logic [DW-1:0] d);
        ld_data = d; ld_we = 1'b1;
        @(negedge clk_a);
        ld_we = 1'b0;
    endtask

    task automatic check_bank(input string tag, input logic [4*OW-1:0] exp);
        chk({tag, " y1"}, DW'(y1_o), DW'(exp[4*OW-1:3*OW]));
        chk({tag, " x1"}, DW'(x1_o), DW'(exp[3*OW-1:2*OW]));
        chk({tag, " y2"}, DW'(y2_o), DW'(exp[2*OW-1:OW]));
        chk({tag, " x2"}, DW'(x2_o), DW'(exp[OW-1:0]));
    endtask

    task automatic wait_rdy_b();
        repeat (5) @(negedge clk_b);
        @(negedge clk_a);
    endtask

    // Parity layout: value bits 7:0 low, bit 8 junk, value bits 12:8 at 13:9, junk above
    function automatic logic [DW-1:0] mk_par(input logic [OW-1:0] v, input logic junk);
        logic [DW-1:0] d;
        d = '1;
        d[7:0]  = v[7:0];
        d[8]    = junk;
        d[13:9] = v[12:8];
        return d;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk_a);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [4*OW-1:0] flat;
        logic [3:0]      gap;
        logic [4*OW-1:0] pvals;

        // Reset state (R10), serial straps
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 rdy_a", DW'(rdy_a_o), '0);
        chk("R10 rdy_b", DW'(rdy_b_o), '0);
        check_bank("R10", '0);

        // Vector loop: serial loads with idle gaps
        for (int v = 0; v < NV; v++) begin
            flat = VEC[v][4*OW+3:4];
            gap  = VEC[v][3:0];
            if (v != 0) do_reset(1'b0, 1'b0, 1'b1, 1'b0);
            for (int i = 0; i < 4*OW; i++) begin
                if (gap != 0 && i != 0 && (i % gap) == 0) idle_one(~flat[4*OW-1-i]);
                if (i == 4*OW-1) chk("R4 rdy_a low before last bit", DW'(rdy_a_o), '0);
                shift_one(flat[4*OW-1-i]);
            end
            chk("R4 rdy_a low on last-bit edge", DW'(rdy_a_o), '0);
            chk("R5 rdy_b low on last-bit edge", DW'(rdy_b_o), '0);
            @(negedge clk_a);
            chk("R4 rdy_a high next edge", DW'(rdy_a_o), 1);
            chk("R5 rdy_b still low", DW'(rdy_b_o), '0);
            check_bank("R2 R3 serial", flat);
            wait_rdy_b();
            chk("R5 rdy_b after sync", DW'(rdy_b_o), 1);
        end

        // Extra serial bits after completion (R9)
        for (int i = 0; i < 20; i++) shift_one(1'b0);
        check_bank("R9 extra serial", VEC[NV-1][4*OW+3:4]);
        chk("R9 rdy_a kept", DW'(rdy_a_o), 1);

        // Interspersed parity refuses serial mode (R6), then parity parallel load (R7, R8)
        do_reset(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 4*OW; i++) shift_one(1'b1);
        @(negedge clk_a);
        chk("R6 rdy_a low after serial bits", DW'(rdy_a_o), '0);
        check_bank("R6 serial ignored", '0);
        wait_rdy_b();
        chk("R6 rdy_b low", DW'(rdy_b_o), '0);
        pvals = {13'd1234, 13'd8188, 13'd1, 13'h0F0F};
        par_write(mk_par(pvals[4*OW-1:3*OW], 1'b1));
        par_write(mk_par(pvals[3*OW-1:2*OW], 1'b0));
        par_write(mk_par(pvals[2*OW-1:OW],   1'b1));
        chk("R7 rdy_a low after three words", DW'(rdy_a_o), '0);
        par_write(mk_par(pvals[OW-1:0],      1'b1));
        chk("R7 rdy_a low on fourth-word edge", DW'(rdy_a_o), '0);
        @(negedge clk_a);
        chk("R7 rdy_a high next edge", DW'(rdy_a_o), 1);
        check_bank("R8 R7 parity words", pvals);
        par_write(mk_par(13'd77, 1'b0));
        check_bank("R9 extra parallel write", pvals);
        wait_rdy_b();
        chk("R5 rdy_b parallel", DW'(rdy_b_o), 1);

        // Non-serial strap (shift_bit=1) selects parallel, no parity (R1, R8)
        do_reset(1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4*OW; i++) shift_one(1'b1);
        @(negedge clk_a);
        chk("R1 serial bits ignored in parallel mode", DW'(rdy_a_o), '0);
        check_bank("R1 bank untouched", '0);
        pvals = {13'h0100, 13'h1FFC, 13'h0155, 13'h0001};
        for (int w = 0; w < 4; w++) begin
            par_write({{(DW-OW){1'b1}}, pvals[(3-w)*OW +: OW]});
        end
        @(negedge clk_a);
        chk("R7 rdy_a no parity", DW'(rdy_a_o), 1);
        check_bank("R8 no parity words", pvals);

        // mode_hi strap also selects parallel (R1)
        do_reset(1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4*OW; i++) shift_one(1'b1);
        @(negedge clk_a);
        chk("R1 mode_hi parallel", DW'(rdy_a_o), '0);

        // Reset mid-load clears flags (R10)
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) shift_one(1'b1);
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        check_bank("R10 after re-reset", '0);
        chk("R10 rdy_b after re-reset", DW'(rdy_b_o), '0);

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule